// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block turns a bank of wired interrupt lines into message-signalled interrupt writes. Each line has a trigger mode (level-high or rising-edge), a pending flag and a 22-bit vector that carries a device identifier and an event identifier. When a line fires, the block raises its pending flag and sends one message on a valid/ready output. The message holds the line's two identifiers and a doorbell address that is fixed by a parameter. No second message leaves for that line until software ends the interrupt through a write-one-to-clear register.

Software reaches the block through a simple 32-bit register port with separate write and read strobes; read data comes back one clock after the read strobe. Lines are grouped into nodes of 128. Global line numbers 0 to 63 are reserved, so global line `p` sits in node `(p-64)/128 + 1` at local index `(p-64) mod 128`, and node 0 holds no lines. Inputs are resynchronised by two flops. A round-robin arbiter picks which queued line is sent next.

Top module: `irq_msg_bridge`

## Requirements
- R1: A vector register keeps bits [21:0] of the written word. The device identifier is bits [11:0] and the event identifier is bits [21:12]; bits [31:22] read as zero. A write replaces the whole field, so a read-modify-write that changes only the event field leaves the device field unchanged.
- R2: Node `n` (1..NUM_NODES) has its window at byte address `n*0x1000`. The vector of local line `i` is at `n*0x1000 + 0x200 + 4*i`. The trigger-mode bit of local line `i` is bit `i%32` of the word at `n*0x1000 + 4*(i/32)`; 1 selects level-high and 0 selects rising-edge.
- R3: After reset all vectors and mode bits read zero (rising-edge), no line is pending, and `msgValid` is low.
- R4: Reads of any address that is neither a vector nor a mode word return zero. This covers node 0, nodes above NUM_NODES, gaps inside a node, and the clear region, which is write-only.
- R5: A rising-edge line sends exactly one message per 0-to-1 transition of its input. While it is pending it sends nothing more, and after a clear it sends nothing until a new transition arrives.
- R6: A level-high line sends a message while its input is 1. If the input is still 1 when the line is cleared, it sends another message. If the input has fallen before the clear, it sends none.
- R7: Writing 1 to bit `p%32` of the word at `0xA000 + 4*(p/32)` clears global line `p`. Zero bits, and bits that belong to reserved lines 0..63, have no effect.
- R8: A rising edge on a line that is still pending is remembered. After the clear, that line sends one message without needing a further edge.
- R9: When several lines are queued, they are sent in ascending local index order, starting after the last line that was sent and wrapping around. After reset the search starts at index 0.
- R10: Only one message is presented at a time. While `msgValid` is high and `msgReady` is low, `msgDevId` and `msgEventId` stay stable. `msgAddr` always equals the DOORBELL parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_NODES*PINS_PER_NODE | Wired interrupt lines, indexed by node-major local index |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRdEn |
| msgValid | output | 1 | Message present |
| msgReady | input | 1 | Message accepted when high with msgValid |
| msgAddr | output | DOORBELL_W | Fixed doorbell address |
| msgDevId | output | 12 | Device identifier of the line being sent |
| msgEventId | output | 10 | Event identifier of the line being sent |

## Verification
The hardest case to reach from the ports is a rising edge that arrives while a line is still pending. To reach it, the stimulus lowers and raises the line between the first message and the clear, then checks that exactly one message follows the clear. Round-robin order also depends on which line was sent last, so the stimulus raises random sets of lines in the same cycle while that pointer sits at different places. It holds `msgReady` low for random stretches and checks that the payload stays put.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 16;
  localparam int VEC_W  = 22;

  typedef enum logic [1:0] {RD_NONE, RD_TYPE, RD_VEC} rdSel_e;

  typedef struct packed {
    logic             vecWr;
    logic             typeWr;
    logic             clrWr;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] pinIdx;
    logic [IDX_W-1:0] wordIdx;
    logic [31:0]      wdata;
  } strobe_t;
endpackage

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int NUM_NODES     = 1,
  parameter int PINS_PER_NODE = 128
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobe_t           stb
);
  localparam int TYPE_WORDS = PINS_PER_NODE / 32;
  localparam int VEC_BASE   = 'h200;
  localparam int CLR_BASE   = 'hA000;
  localparam int CLR_WORDS  = (64 + NUM_NODES * PINS_PER_NODE + 31) / 32;

  int  nodeNum, offs, absAddr;
  logic nodeOk, isType, isVec, isClr;

  always_comb begin
    nodeNum = int'(busAddr[15:12]);
    offs    = int'(busAddr[11:0]);
    absAddr = int'(busAddr);
    nodeOk  = (nodeNum >= 1) && (nodeNum <= NUM_NODES);
    isType  = nodeOk && (offs < TYPE_WORDS * 4);
    isVec   = nodeOk && (offs >= VEC_BASE) && (offs < VEC_BASE + PINS_PER_NODE * 4);
    isClr   = (absAddr >= CLR_BASE) && (absAddr < CLR_BASE + CLR_WORDS * 4);

    stb        = '0;
    stb.wdata  = busWdata;
    stb.rdEn   = busRdEn;
    stb.vecWr  = busWrEn && isVec;
    stb.typeWr = busWrEn && isType;
    stb.clrWr  = busWrEn && isClr;
    stb.rdSel  = isVec ? RD_VEC : (isType ? RD_TYPE : RD_NONE);
    if (isVec)
      stb.pinIdx = IDX_W'((nodeNum - 1) * PINS_PER_NODE + ((offs - VEC_BASE) >> 2));
    if (isType)
      stb.wordIdx = IDX_W'((nodeNum - 1) * TYPE_WORDS + (offs >> 2));
    else if (isClr)
      stb.wordIdx = IDX_W'((absAddr - CLR_BASE) >> 2);
  end

  // R2: a decoded address selects at most one register kind
  always_comb begin
    assert_one_target_R2: assert ($onehot0({stb.vecWr, stb.typeWr, stb.clrWr}));
  end
endmodule

// File: rtl/irq_msg_dp.sv
module irq_msg_dp
  import irq_msg_pkg::*;
#(
  parameter int NUM_NODES     = 1,
  parameter int PINS_PER_NODE = 128
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_NODES*PINS_PER_NODE-1:0]    irqIn,
  input  strobe_t                               stb,
  output logic [31:0]                           busRdata,
  output logic                                  msgValid,
  input  logic                                  msgReady,
  output logic [11:0]                           msgDevId,
  output logic [9:0]                            msgEventId
);
  localparam int N      = NUM_NODES * PINS_PER_NODE;
  localparam int PW     = $clog2(N);
  localparam int RSV    = 64;
  localparam int TWORDS = N / 32;

  logic [N-1:0] sync1, sync2, prevIn, typeBits;
  logic [N-1:0] pend, queued, edgeSeen;
  logic [N-1:0] rise, cond, trig, clrHit, grantVec;
  logic [VEC_W-1:0] vecMem [N];
  logic [PW-1:0] lastGrant;
  logic anyQ, capture, vecSel;
  int pick;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clrHit[i] = stb.clrWr && (stb.wordIdx == IDX_W'((RSV + i) / 32))
                       && stb.wdata[(RSV + i) % 32];
  end

  always_comb begin
    rise = sync2 & ~prevIn;
    cond = (typeBits & sync2) | (~typeBits & (rise | edgeSeen));
    trig = cond & ~pend & ~queued;
  end

  // round-robin search starting after the last grant
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = 0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(lastGrant) + 1 + k) % N;
      if (!found && queued[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
    anyQ     = found;
    capture  = !msgValid && anyQ;
    grantVec = '0;
    if (capture) grantVec[pick] = 1'b1;
    vecSel = int'(stb.pinIdx) < N;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= '0; sync2 <= '0; prevIn <= '0; typeBits <= '0;
      pend <= '0; queued <= '0; edgeSeen <= '0;
      for (int i = 0; i < N; i++) vecMem[i] <= '0;
      lastGrant <= PW'(N - 1);
      msgValid <= 1'b0; msgDevId <= '0; msgEventId <= '0;
      busRdata <= '0;
    end else begin
      sync1    <= irqIn;
      sync2    <= sync1;
      prevIn   <= sync2;
      pend     <= (pend | trig) & ~clrHit;
      queued   <= (queued | trig) & ~grantVec;
      edgeSeen <= (edgeSeen | (rise & (pend | queued) & ~typeBits)) & ~trig;
      for (int w = 0; w < TWORDS; w++)
        if (stb.typeWr && stb.wordIdx == IDX_W'(w)) typeBits[w*32 +: 32] <= stb.wdata;
      if (stb.vecWr && vecSel) vecMem[stb.pinIdx[PW-1:0]] <= stb.wdata[VEC_W-1:0];
      if (stb.rdEn) begin
        busRdata <= '0;
        if (stb.rdSel == RD_VEC && vecSel)
          busRdata <= {{(32-VEC_W){1'b0}}, vecMem[stb.pinIdx[PW-1:0]]};
        else if (stb.rdSel == RD_TYPE)
          for (int w = 0; w < TWORDS; w++)
            if (stb.wordIdx == IDX_W'(w)) busRdata <= typeBits[w*32 +: 32];
      end
      if (msgValid && msgReady) begin
        msgValid <= 1'b0;
      end else if (capture) begin
        msgValid   <= 1'b1;
        msgDevId   <= vecMem[pick][11:0];
        msgEventId <= vecMem[pick][21:12];
        lastGrant  <= PW'(pick);
      end
    end
  end

  assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDevId) && $stable(msgEventId)));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit != '0) |=> ((pend & $past(clrHit)) == '0));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == RD_NONE) |=> (busRdata == 32'd0));

  assert_vec_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecWr && vecSel) |=> (vecMem[$past(stb.pinIdx[PW-1:0])] == $past(stb.wdata[VEC_W-1:0])));

  assert_msg_from_queue_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> ($past(queued) != '0));
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import irq_msg_pkg::*;
#(
  parameter int              NUM_NODES     = 1,
  parameter int              PINS_PER_NODE = 128,
  parameter int              DOORBELL_W    = 32,
  parameter logic [DOORBELL_W-1:0] DOORBELL = 32'h0801_0040
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_NODES*PINS_PER_NODE-1:0] irqIn,
  input  logic                               busWrEn,
  input  logic                               busRdEn,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [31:0]                        busWdata,
  output logic [31:0]                        busRdata,
  output logic                               msgValid,
  input  logic                               msgReady,
  output logic [DOORBELL_W-1:0]              msgAddr,
  output logic [11:0]                        msgDevId,
  output logic [9:0]                         msgEventId
);
  strobe_t stb;

  assign msgAddr = DOORBELL;

  irq_msg_ctrl #(.NUM_NODES(NUM_NODES), .PINS_PER_NODE(PINS_PER_NODE)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb));

  irq_msg_dp #(.NUM_NODES(NUM_NODES), .PINS_PER_NODE(PINS_PER_NODE)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .busRdata(busRdata),
    .msgValid(msgValid), .msgReady(msgReady),
    .msgDevId(msgDevId), .msgEventId(msgEventId));
endmodule

// File: tb/sim_irq_msg_bridge.sv
`timescale 1ns/1ps
module sim_irq_msg_bridge;
  localparam int N = 128;
  localparam logic [31:0] DB = 32'h0801_0040;

  logic clk = 0, rstN = 0;
  logic [N-1:0] irqIn = '0;
  logic busWrEn = 0, busRdEn = 0, msgReady = 0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, msgAddr;
  logic msgValid;
  logic [11:0] msgDevId;
  logic [9:0] msgEventId;

  int checks = 0, failures = 0, lastIdx = N - 1;
  int evTab [N];

  always #2 clk = ~clk;

  irq_msg_bridge u0 (.clk(clk), .rstN(rstN), .irqIn(irqIn), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr),
    .msgDevId(msgDevId), .msgEventId(msgEventId));

  function automatic logic [15:0] vecAddr(int i); return 16'(32'h1200 + 4*i); endfunction
  function automatic logic [15:0] clrAddr(int i); return 16'(32'hA000 + 4*((64+i)/32)); endfunction
  function automatic logic [31:0] clrBit(int i); return 32'd1 << ((64+i)%32); endfunction
  function automatic int nextRR(logic [N-1:0] s, int last);
    for (int k = 0; k < N; k++) if (s[(last+1+k)%N]) return (last+1+k)%N;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic busRead(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1;
    @(negedge clk); busRdEn = 0; d = busRdata;
  endtask

  // waits for a message, holds ready low for 'hold' cycles checking stability, then accepts
  task automatic getMsg(int timeout, int hold, output bit got, output int idx, output int ev);
    got = 0; idx = -1; ev = 0;
    for (int t = 0; t < timeout && !got; t++) begin
      @(negedge clk);
      if (msgValid) got = 1;
    end
    if (got) begin
      logic [11:0] d0; logic [9:0] e0;
      d0 = msgDevId; e0 = msgEventId;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(msgValid && msgDevId == d0 && msgEventId == e0, "R10", "payload held", {msgDevId, msgEventId}, {d0, e0});
      end
      chk(msgAddr == DB, "R10", "doorbell", msgAddr, DB);
      idx = int'(msgDevId) - 'h100; ev = int'(msgEventId);
      msgReady = 1; @(negedge clk); msgReady = 0;
      if (idx >= 0 && idx < N) lastIdx = idx;
    end
  endtask

  task automatic expectMsg(string req, int pin);
    bit got; int idx, ev;
    getMsg(40, 0, got, idx, ev);
    chk(got && idx == pin, req, "message pin", idx, pin);
    if (got && idx == pin) chk(ev == evTab[pin], "R1", "event id", ev, evTab[pin]);
  endtask

  task automatic expectNone(string req, int cyc);
    bit seen; seen = 0;
    for (int t = 0; t < cyc; t++) begin @(negedge clk); if (msgValid) seen = 1; end
    chk(!seen, req, "no message", seen, 0);
  endtask

  task automatic clearPin(int i); busWrite(clrAddr(i), clrBit(i)); endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R3 reset state
    chk(!msgValid, "R3", "msgValid after reset", msgValid, 0);
    busRead(vecAddr(17), rd); chk(rd == 0, "R3", "vector reset", rd, 0);
    busRead(16'h100C, rd);    chk(rd == 0, "R3", "type reset", rd, 0);

    // program vectors: device = 0x100+i, random event
    for (int i = 0; i < N; i++) begin
      evTab[i] = int'($urandom % 1024);
      busWrite(vecAddr(i), {10'h3FF, 10'(evTab[i]), 12'(32'h100 + i)});
    end
    for (int k = 0; k < 4; k++) begin
      int i; i = int'($urandom % N);
      busRead(vecAddr(i), rd);
      chk(rd == {10'd0, 10'(evTab[i]), 12'(32'h100 + i)}, "R1", "vector readback", rd, {10'd0, 10'(evTab[i]), 12'(32'h100 + i)});
    end
    // R1 read-modify-write of event field keeps device
    busRead(vecAddr(90), rd);
    evTab[90] = 'h2A5;
    busWrite(vecAddr(90), (rd & ~32'h003FF000) | (32'h2A5 << 12));
    busRead(vecAddr(90), rd);
    chk(rd[11:0] == 12'h100 + 12'd90, "R1", "device kept", rd[11:0], 12'h100 + 12'd90);
    chk(rd[21:12] == 10'h2A5, "R1", "event updated", rd[21:12], 10'h2A5);

    // R4 unmapped reads
    busRead(16'h0200, rd); chk(rd == 0, "R4", "node0", rd, 0);
    busRead(16'h2200, rd); chk(rd == 0, "R4", "node2", rd, 0);
    busRead(16'h1100, rd); chk(rd == 0, "R4", "gap", rd, 0);
    busRead(16'hA008, rd); chk(rd == 0, "R4", "clear region", rd, 0);

    // R5 edge pin 5
    irqIn[5] = 1; expectMsg("R5", 5);
    expectNone("R5", 20);
    clearPin(5); expectNone("R5", 20);
    irqIn[5] = 0; repeat (5) @(negedge clk);
    irqIn[5] = 1; expectMsg("R5", 5);
    clearPin(5); irqIn[5] = 0;

    // R8 edge while pending
    irqIn[7] = 1; expectMsg("R8", 7);
    irqIn[7] = 0; repeat (5) @(negedge clk);
    irqIn[7] = 1; repeat (5) @(negedge clk);
    expectNone("R8", 5);
    clearPin(7); expectMsg("R8", 7);
    irqIn[7] = 0; repeat (4) @(negedge clk);
    clearPin(7); expectNone("R8", 20);

    // R2/R6 level pin 40: type word 0x1004 bit 8
    busWrite(16'h1004, 32'h0000_0100);
    busRead(16'h1004, rd); chk(rd == 32'h100, "R2", "type readback", rd, 32'h100);
    irqIn[40] = 1; expectMsg("R6", 40);
    clearPin(40); expectMsg("R6", 40);
    irqIn[40] = 0; repeat (5) @(negedge clk);
    clearPin(40); expectNone("R6", 20);
    // R7: reserved and zero bits do nothing
    irqIn[40] = 1; expectMsg("R6", 40);
    busWrite(16'hA000, 32'hFFFF_FFFF); busWrite(16'hA004, 32'hFFFF_FFFF);
    expectNone("R7", 20);
    busWrite(clrAddr(40), 32'h0); expectNone("R7", 20);
    clearPin(40); expectMsg("R7", 40);
    irqIn[40] = 0; repeat (5) @(negedge clk); clearPin(40);
    busWrite(16'h1004, 32'h0);

    // R9 directed round robin with hold
    begin
      logic [N-1:0] s; bit got; int idx, ev;
      s = '0; s[3] = 1; s[10] = 1; s[20] = 1;
      irqIn = irqIn | s;
      while (s != '0) begin
        int e; e = nextRR(s, lastIdx);
        getMsg(40, 3, got, idx, ev);
        chk(got && idx == e, "R9", "rr order", idx, e);
        if (e >= 0) s[e] = 0;
      end
      for (int i = 0; i < N; i++) if (i == 3 || i == 10 || i == 20) begin clearPin(i); irqIn[i] = 0; end
    end

    // random sets of simultaneous edges
    for (int it = 0; it < 6; it++) begin
      logic [N-1:0] s, all; bit got; int idx, ev;
      s = '0;
      for (int i = 0; i < N; i++) if (($urandom % 8) == 0) s[i] = 1;
      if (s == '0) s[it] = 1;
      all = s;
      repeat (4) @(negedge clk);
      irqIn = s;
      while (s != '0) begin
        int e; e = nextRR(s, lastIdx);
        getMsg(40, int'($urandom % 3), got, idx, ev);
        chk(got && idx == e, "R9", "random rr order", idx, e);
        if (got && idx == e) chk(ev == evTab[e], "R1", "random event", ev, evTab[e]);
        if (e >= 0) s[e] = 0;
      end
      expectNone("R5", 10);
      for (int w = 2; w < 6; w++) begin
        logic [31:0] m; m = '0;
        for (int b = 0; b < 32; b++) if (w*32 + b - 64 >= 0 && w*32 + b - 64 < N && all[w*32+b-64]) m[b] = 1;
        if (m != 0) busWrite(16'(32'hA000 + 4*w), m);
      end
      irqIn = '0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule